// File: doc/BRIEF.md
# Second-Operand Barrel Shifter with Zero-Amount Remapping

This block builds the second ALU operand of a load/store RISC datapath and the shifter carry that goes with it. It has no clock: the result and the carry follow the inputs within the same cycle. A two-bit form select picks the operand form. The first is an 8-bit constant rotated by an even amount. The second is a register value shifted by a 5-bit count taken from the instruction. The third is a register value shifted by a count held in a second register. The fourth is the register value passed through untouched.

There are four shift kinds: logical left, logical right, arithmetic right and rotate right. When the instruction gives a count of zero, it does not always mean "no shift". Logical right and arithmetic right by zero become shifts by 32. Rotate right by zero becomes a 33-bit rotate through the carry. When the count comes from a register, counts of 32 and above saturate, each shift kind in its own way.

Top module: `opshift_top`

## Requirements
- R1: Form code 0 (immediate) zero-extends `opnd_i[7:0]` and rotates it right by twice `amt_i[3:0]`. The result is `result_o`. Bits `opnd_i[31:8]` and `amt_i[31:4]` have no effect.
- R2: In form 0, a rotate field of zero gives `carry_o = carry_i`. A nonzero rotate field gives `carry_o = result_o[31]`.
- R3: Form code 1 (count from the instruction) shifts `opnd_i` by `amt_i[4:0]`. Kind codes are 0 logical left, 1 logical right, 2 arithmetic right and 3 rotate right. For counts 1 to 31, `carry_o` is the last bit shifted out. For rotate, that bit is the new bit 31. Bits `amt_i[31:5]` have no effect.
- R4: In form 1, rotate right with a count of zero gives `{carry_i, opnd_i[31:1]}`, with `carry_o = opnd_i[0]`.
- R5: In form 1, logical right with a count of zero gives 0, with `carry_o = opnd_i[31]`. Arithmetic right with a count of zero fills every bit with `opnd_i[31]`, with `carry_o = opnd_i[31]`.
- R6: In form 1, logical left with a count of zero gives `opnd_i` unchanged, with `carry_o = carry_i`.
- R7: Form code 2 (count from a register) uses only `amt_i[7:0]`. A count of zero gives `opnd_i` unchanged with `carry_o = carry_i`. Counts from 1 to 31 shift as in R3.
- R8: In form 2, a logical shift by exactly 32 gives 0. Its carry is `opnd_i[0]` for left and `opnd_i[31]` for right. A logical shift by more than 32 gives 0 with carry 0.
- R9: In form 2, arithmetic right by 32 or more fills every bit with `opnd_i[31]`, with `carry_o = opnd_i[31]`.
- R10: In form 2, a rotate right by a count of 32 or more rotates by the count modulo 32. A nonzero multiple of 32 gives `opnd_i` unchanged, with `carry_o = opnd_i[31]`.
- R11: Form code 3 passes `opnd_i` through unchanged, with `carry_o = carry_i`, whatever the kind and count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_i | input | 32 | Register value, or the 8-bit constant in the low byte for form 0 |
| amt_i | input | 32 | Count value: rotate field, instruction count or amount register |
| kind_i | input | 2 | Shift kind: 0 LSL, 1 LSR, 2 ASR, 3 ROR |
| form_i | input | 2 | Operand form: 0 immediate, 1 instruction count, 2 register count, 3 plain |
| carry_i | input | 1 | Incoming carry flag |
| result_o | output | 32 | Shifted second operand |
| carry_o | output | 1 | Shifter carry-out |

## Verification
Directed vectors cover every form and kind at the counts where the behaviour changes: zero, one, 31, 32, 33 and large register counts. Each one separates a remapped zero, or a saturated count, from an ordinary shift. Alternating-bit and single-bit operands with a set sign bit show the difference between the logical fill and the arithmetic fill. Both polarities of the incoming carry show whether the carry was kept or replaced. Random vectors with noise in the ignored upper bits of the operand and of the count confirm that only the documented fields are decoded.

// File: rtl/opshift_pkg.sv
`timescale 1ns/1ps
package opshift_pkg;

    localparam int IMM_W = 8;   // width of the rotated constant
    localparam int ROT_W = 4;   // width of the immediate rotate field
    localparam int ISH_W = 5;   // width of the instruction-given count
    localparam int RSH_W = 8;   // bits of the amount register that are used

    typedef enum logic [1:0] {
        SH_LSL = 2'd0,
        SH_LSR = 2'd1,
        SH_ASR = 2'd2,
        SH_ROR = 2'd3
    } shift_kind_e;

    typedef enum logic [1:0] {
        SRC_IMM    = 2'd0,
        SRC_ISHIFT = 2'd1,
        SRC_RSHIFT = 2'd2,
        SRC_PLAIN  = 2'd3
    } operand_form_e;

    // Normalised request handed from the decoder to the shift core.
    typedef struct packed {
        shift_kind_e        kind;
        logic [RSH_W-1:0]   amount;
        logic               rrx;
    } shift_req_t;

endpackage

// File: rtl/opshift_decode.sv
`timescale 1ns/1ps
module opshift_decode
    import opshift_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   form_i,
    input  logic [1:0]   kind_i,
    input  logic [W-1:0] opnd_i,
    input  logic [W-1:0] amt_i,
    output logic [W-1:0] src_o,
    output shift_req_t   req_o
);

    localparam logic [RSH_W-1:0] FULL_AMT = RSH_W'(W);

    logic [W-1:0] src_d;
    shift_req_t   req_d;

    always_comb begin
        src_d       = opnd_i;
        req_d.kind  = shift_kind_e'(kind_i);
        req_d.amount = '0;
        req_d.rrx   = 1'b0;
        unique case (operand_form_e'(form_i))
            SRC_IMM: begin
                // constant rotated right by an even amount
                src_d        = {{(W-IMM_W){1'b0}}, opnd_i[IMM_W-1:0]};
                req_d.kind   = SH_ROR;
                req_d.amount = RSH_W'({amt_i[ROT_W-1:0], 1'b0});
            end
            SRC_ISHIFT: begin
                req_d.amount = RSH_W'(amt_i[ISH_W-1:0]);
                if (amt_i[ISH_W-1:0] == '0) begin
                    unique case (shift_kind_e'(kind_i))
                        SH_LSR,
                        SH_ASR: req_d.amount = FULL_AMT;
                        SH_ROR: req_d.rrx    = 1'b1;
                        default: req_d.amount = '0;
                    endcase
                end
            end
            SRC_RSHIFT: begin
                req_d.amount = amt_i[RSH_W-1:0];
            end
            default: begin
                req_d.kind   = SH_LSL;
                req_d.amount = '0;
            end
        endcase
    end

    assign src_o = src_d;
    assign req_o = req_d;

endmodule

// File: rtl/opshift_rotr.sv
`timescale 1ns/1ps
module opshift_rotr #(
    parameter int W = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   x_i,
    input  logic [SHW-1:0] r_i,
    output logic [W-1:0]   y_o
);

    logic [SHW:0][W-1:0] stage;

    assign stage[0] = x_i;

    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int D = 1 << s;
        assign stage[s+1] = r_i[s] ? {stage[s][D-1:0], stage[s][W-1:D]}
                                   : stage[s];
    end

    assign y_o = stage[SHW];

endmodule

// File: rtl/opshift_core.sv
`timescale 1ns/1ps
module opshift_core
    import opshift_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] src_i,
    input  shift_req_t   req_i,
    input  logic         carry_i,
    output logic [W-1:0] result_o,
    output logic         carry_o
);

    localparam int SHW = $clog2(W);
    localparam logic [RSH_W-1:0] FULL_AMT = RSH_W'(W);

    typedef struct packed {
        logic [W-1:0] value;
        logic         carry;
    } core_out_t;

    core_out_t     out_d;
    logic [W:0]    left_ext;
    logic [W:0]    right_ext;
    logic [W:0]    arith_ext;
    logic [RSH_W-1:0] arith_amt;
    logic [W-1:0]  rot_val;

    opshift_rotr #(.W(W)) u_rotr (
        .x_i (src_i),
        .r_i (req_i.amount[SHW-1:0]),
        .y_o (rot_val)
    );

    always_comb begin
        left_ext  = {1'b0, src_i} << req_i.amount;
        right_ext = {src_i, 1'b0} >> req_i.amount;
        arith_amt = (req_i.amount > FULL_AMT) ? FULL_AMT : req_i.amount;
        arith_ext = $signed({src_i, 1'b0}) >>> arith_amt;

        out_d.value = src_i;
        out_d.carry = carry_i;
        if (req_i.rrx) begin
            out_d.value = {carry_i, src_i[W-1:1]};
            out_d.carry = src_i[0];
        end else if (req_i.amount != '0) begin
            unique case (req_i.kind)
                SH_LSL: begin
                    out_d.value = left_ext[W-1:0];
                    out_d.carry = left_ext[W];
                end
                SH_LSR: begin
                    out_d.value = right_ext[W:1];
                    out_d.carry = right_ext[0];
                end
                SH_ASR: begin
                    out_d.value = arith_ext[W:1];
                    out_d.carry = arith_ext[0];
                end
                default: begin
                    out_d.value = rot_val;
                    out_d.carry = rot_val[W-1];
                end
            endcase
        end
    end

    assign result_o = out_d.value;
    assign carry_o  = out_d.carry;

endmodule

// File: rtl/opshift_top.sv
`timescale 1ns/1ps
module opshift_top
    import opshift_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opnd_i,
    input  logic [W-1:0] amt_i,
    input  logic [1:0]   kind_i,
    input  logic [1:0]   form_i,
    input  logic         carry_i,
    output logic [W-1:0] result_o,
    output logic         carry_o
);

    logic [W-1:0] src;
    shift_req_t   req;

    opshift_decode #(.W(W)) u_decode (
        .form_i (form_i),
        .kind_i (kind_i),
        .opnd_i (opnd_i),
        .amt_i  (amt_i),
        .src_o  (src),
        .req_o  (req)
    );

    opshift_core #(.W(W)) u_core (
        .src_i    (src),
        .req_i    (req),
        .carry_i  (carry_i),
        .result_o (result_o),
        .carry_o  (carry_o)
    );

endmodule

// File: rtl/opshift_chk.sv
`timescale 1ns/1ps
module opshift_chk #(
    parameter int W = 32
) (
    input logic [W-1:0] opnd_i,
    input logic [W-1:0] amt_i,
    input logic [1:0]   kind_i,
    input logic [1:0]   form_i,
    input logic         carry_i,
    input logic [W-1:0] result_o,
    input logic         carry_o
);

    always_comb begin
        if (form_i == 2'd0 && amt_i[3:0] == 4'd0) begin
            assert_imm_norot_R2: assert (carry_o == carry_i &&
                                         result_o == {{(W-8){1'b0}}, opnd_i[7:0]})
                else $error("imm zero rotate mismatch");
        end
        if (form_i == 2'd1 && kind_i == 2'd3 && amt_i[4:0] == 5'd0) begin
            assert_rrx_R4: assert (result_o == {carry_i, opnd_i[W-1:1]} &&
                                   carry_o == opnd_i[0])
                else $error("rotate-extended mismatch");
        end
        if (form_i == 2'd1 && kind_i == 2'd1 && amt_i[4:0] == 5'd0) begin
            assert_lsr_full_R5: assert (result_o == '0 && carry_o == opnd_i[W-1])
                else $error("logical right by full width mismatch");
        end
        if (form_i == 2'd1 && kind_i == 2'd0 && amt_i[4:0] == 5'd0) begin
            assert_lsl_zero_R6: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("left by zero mismatch");
        end
        if (form_i == 2'd2 && amt_i[7:0] == 8'd0) begin
            assert_reg_zero_R7: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("register zero count mismatch");
        end
        if (form_i == 2'd2 && kind_i[1] == 1'b0 && amt_i[7:0] > 8'd32) begin
            assert_logic_sat_R8: assert (result_o == '0 && carry_o == 1'b0)
                else $error("logical saturation mismatch");
        end
        if (form_i == 2'd2 && kind_i == 2'd2 && amt_i[7:0] >= 8'd32) begin
            assert_arith_sat_R9: assert (result_o == {W{opnd_i[W-1]}} &&
                                         carry_o == opnd_i[W-1])
                else $error("arithmetic saturation mismatch");
        end
        if (form_i == 2'd3) begin
            assert_plain_R11: assert (result_o == opnd_i && carry_o == carry_i)
                else $error("plain form mismatch");
        end
    end

endmodule

bind opshift_top opshift_chk #(.W(W)) u_chk (
    .opnd_i   (opnd_i),
    .amt_i    (amt_i),
    .kind_i   (kind_i),
    .form_i   (form_i),
    .carry_i  (carry_i),
    .result_o (result_o),
    .carry_o  (carry_o)
);

// File: tb/opshift_top_tb.sv
`timescale 1ns/1ps
module opshift_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] opnd;
    logic [31:0] amt;
    logic [1:0]  kind;
    logic [1:0]  form;
    logic        cin;
    logic [31:0] res;
    logic        cout;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    opshift_top u_dut (
        .opnd_i   (opnd),
        .amt_i    (amt),
        .kind_i   (kind),
        .form_i   (form),
        .carry_i  (cin),
        .result_o (res),
        .carry_o  (cout)
    );

    // Behavioural model: one bit per step, carry = last bit that left.
    task automatic model(input logic [1:0] f, input logic [1:0] k,
                         input logic [31:0] x, input logic [31:0] a,
                         input logic c, output logic [31:0] r, output logic co);
        int n;
        r  = x;
        co = c;
        if (f == 2'd3) return;
        if (f == 2'd0) begin
            r = {24'd0, x[7:0]};
            n = 2 * int'(a[3:0]);
            for (int i = 0; i < n; i++) begin
                co = r[0];
                r  = {r[0], r[31:1]};
            end
            return;
        end
        if (f == 2'd1) begin
            n = int'(a[4:0]);
            if (n == 0) begin
                if (k == 2'd1 || k == 2'd2) n = 32;
                else if (k == 2'd3) begin
                    co = x[0];
                    r  = {c, x[31:1]};
                    return;
                end
            end
        end else begin
            n = int'(a[7:0]);
        end
        for (int i = 0; i < n; i++) begin
            case (k)
                2'd0: begin co = r[31]; r = {r[30:0], 1'b0}; end
                2'd1: begin co = r[0];  r = {1'b0, r[31:1]}; end
                2'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
                default: begin co = r[0]; r = {r[0], r[31:1]}; end
            endcase
        end
    endtask

    function automatic string tag_of(input logic [1:0] f, input logic [1:0] k,
                                     input logic [31:0] a);
        case (f)
            2'd0: return (a[3:0] == 0) ? "R2" : "R1";
            2'd1: begin
                if (a[4:0] != 0) return "R3";
                if (k == 2'd0) return "R6";
                if (k == 2'd3) return "R4";
                return "R5";
            end
            2'd2: begin
                if (a[7:0] < 8'd32) return "R7";
                if (k[1] == 1'b0) return "R8";
                if (k == 2'd2) return "R9";
                return "R10";
            end
            default: return "R11";
        endcase
    endfunction

    task automatic apply(input logic [1:0] f, input logic [1:0] k,
                         input logic [31:0] x, input logic [31:0] a, input logic c);
        logic [31:0] er;
        logic        ec;
        @(posedge clk);
        #1;
        form = f; kind = k; opnd = x; amt = a; cin = c;
        model(f, k, x, a, c, er, ec);
        @(negedge clk);
        checks++;
        if (res !== er || cout !== ec) begin
            fails++;
            $display("FAIL %s form=%0d kind=%0d opnd=%h amt=%h cin=%0b: got %h/%0b expected %h/%0b",
                     tag_of(f, k, a), f, k, x, a, c, res, cout, er, ec);
        end
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        form = 2'd0; kind = 2'd0; opnd = '0; amt = '0; cin = 1'b0;
        repeat (3) @(posedge clk);
        // reset state: all-zero inputs give a zero operand (R1)
        @(negedge clk);
        checks++;
        if (res !== 32'd0 || cout !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset state: got %h/%0b expected 0/0", res, cout);
        end
        rst_n = 1'b1;

        // R1 / R2: immediate forms, upper noise ignored
        apply(2'd0, 2'd2, 32'hFFFF_FF81, 32'hABCD_0000, 1'b1);
        apply(2'd0, 2'd0, 32'h1234_5681, 32'hFFFF_FFF1, 1'b0);
        apply(2'd0, 2'd1, 32'h0000_00FF, 32'h0000_000F, 1'b0);
        apply(2'd0, 2'd3, 32'h0000_0002, 32'h0000_0004, 1'b1);
        // R3: ordinary instruction counts
        apply(2'd1, 2'd0, 32'h8000_0001, 32'hFFFF_FFE1, 1'b0);
        apply(2'd1, 2'd1, 32'h8000_0001, 32'h0000_001F, 1'b0);
        apply(2'd1, 2'd2, 32'h8000_0000, 32'h0000_001F, 1'b0);
        apply(2'd1, 2'd3, 32'h0000_0001, 32'h0000_0001, 1'b0);
        // R4, R5, R6: remapped zero counts
        apply(2'd1, 2'd3, 32'hAAAA_AAAB, 32'hFFFF_FFE0, 1'b1);
        apply(2'd1, 2'd3, 32'h5555_5554, 32'h0000_0000, 1'b0);
        apply(2'd1, 2'd1, 32'h8000_0000, 32'h0000_0020, 1'b0);
        apply(2'd1, 2'd2, 32'h8000_0000, 32'h0000_0000, 1'b0);
        apply(2'd1, 2'd2, 32'h7FFF_FFFF, 32'h0000_0000, 1'b1);
        apply(2'd1, 2'd0, 32'hDEAD_BEEF, 32'h0000_0000, 1'b1);
        // R7..R10: register counts
        apply(2'd2, 2'd1, 32'hDEAD_BEEF, 32'hFFFF_FF00, 1'b1);
        apply(2'd2, 2'd0, 32'h0000_0003, 32'h0000_0001, 1'b0);
        apply(2'd2, 2'd0, 32'h0000_0001, 32'h0000_0020, 1'b0);
        apply(2'd2, 2'd1, 32'h8000_0000, 32'h0000_0020, 1'b0);
        apply(2'd2, 2'd0, 32'hFFFF_FFFF, 32'h0000_0021, 1'b1);
        apply(2'd2, 2'd1, 32'hFFFF_FFFF, 32'h0000_00FF, 1'b1);
        apply(2'd2, 2'd2, 32'h8000_0000, 32'h0000_0040, 1'b0);
        apply(2'd2, 2'd2, 32'h4000_0000, 32'h0000_0020, 1'b1);
        apply(2'd2, 2'd3, 32'h8000_0001, 32'h0000_0020, 1'b0);
        apply(2'd2, 2'd3, 32'h1234_5678, 32'h0000_0024, 1'b0);
        apply(2'd2, 2'd3, 32'h0000_0001, 32'h0000_00C0, 1'b0);
        // R11: plain form
        apply(2'd3, 2'd3, 32'hCAFE_F00D, 32'h0000_0005, 1'b1);
        apply(2'd3, 2'd1, 32'h0F0F_0F0F, 32'h0000_0020, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] a;
            logic [7:0]  pick;
            a = $urandom;
            pick = 8'($urandom % 6);
            case (pick)
                8'd0: a[7:0] = 8'd0;
                8'd1: a[7:0] = 8'd31;
                8'd2: a[7:0] = 8'd32;
                8'd3: a[7:0] = 8'd33;
                default: ;
            endcase
            apply(2'($urandom), 2'($urandom), $urandom, a, 1'($urandom));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule